// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

A memory-mapped watchdog for a system-on-chip. Software programs a 32-bit down-counter with a tick count and chooses what happens when the count runs out. The four choices are: nothing, a general-purpose interrupt, a non-maskable interrupt, or a request for a full-chip reset. A timer write passes through a short fixed delay line before it reaches the counter. Software therefore loads the count, waits for the delay to pass, and only then selects an action. Periodic rewrites of the count keep the system alive.

A state machine drives the counter and the outputs. Its states are DISARMED, COUNT, ALERT, RST_PULSE and SPENT.

- DISARMED goes to COUNT once the action code is non-zero.
- COUNT decrements the counter on each clock. When the counter is 0 and no load arrives, COUNT moves to ALERT for codes 1 and 2, or to RST_PULSE for code 3.
- ALERT and SPENT return to COUNT when a load arrives.
- RST_PULSE moves to SPENT after its fixed length.
- Every state except RST_PULSE falls back to DISARMED when the action code is 0.

A sticky flag records that the watchdog requested a chip reset. Only the power-on reset input clears this flag. It therefore survives the system reset that the watchdog's own request causes.

Top module: `wdog_action_timer`

## Requirements
- R1: After power-on reset the action code reads 0, the counter reads 0xFFFFFFFF, the last-reset flag reads 0, and all three action outputs are low.
- R2: The control register sits at byte offset 0x0. Bits [1:0] hold the action code (0 none, 1 general interrupt, 2 non-maskable interrupt, 3 chip reset), bit 31 is the last-reset flag, and all other bits read 0. Offset 0x4 reads the live counter. Any other offset reads 0, and writes to it change nothing.
- R3: Every access request is answered by `bus_ready` high on the following cycle, with `bus_rdata` holding the register value from the cycle of the request. Without a request, `bus_ready` stays low.
- R4: A write to offset 0x4 loads the counter exactly LOAD_LAT clock edges after the edge that accepts the write. A read issued before then returns the old count.
- R5: In state COUNT with a non-zero action code, the counter drops by exactly one per clock until it reaches 0. It then stays at 0 until the next load.
- R6: Expiry with code 1 raises `irq_gp`, and expiry with code 2 raises `irq_nmi`. Each is a level that stays high until a load arrives or the action code is set to 0.
- R7: Expiry with code 3 drives `chip_rst_req` high for exactly RST_CYC cycles. Timer loads that arrive during the pulse are dropped, so the counter still reads 0 afterwards.
- R8: The last-reset flag is set on the same edge that starts a chip-reset pulse. It keeps its value through `rst_n` and is cleared only by `por_n`.
- R9: Action code 0 stops the counter, which then holds its value, and drops any interrupt level within two cycles of the write.
- R10: At most one of `irq_gp`, `irq_nmi` and `chip_rst_req` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | System reset, active low; leaves the last-reset flag alone |
| por_n | input | 1 | Power-on reset, active low; clears everything |
| bus_req | input | 1 | Access request strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | One-cycle completion of the previous request |
| irq_gp | output | 1 | General-purpose interrupt level |
| irq_nmi | output | 1 | Non-maskable interrupt level |
| chip_rst_req | output | 1 | Full-chip reset request pulse |

## Verification
The assertions assume the following about the inputs:

- `bus_req` is a synchronous strobe.
- Both resets are held for several clocks.
- The loop from `chip_rst_req` back to `rst_n` is left open. A closed loop would reset the block in the middle of its own pulse.

The stimulus meets these assumptions in four ways:

- It drives the bus only between clock edges.
- It holds each reset for at least three cycles.
- It never wires the reset request back into `rst_n`.
- It spaces requests so that each new one starts only after the previous `bus_ready` has been sampled.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_IRQ      = 2'd1,
        ACT_NMI      = 2'd2,
        ACT_CHIP_RST = 2'd3
    } wd_act_e;

    typedef enum logic [2:0] {
        ST_DISARMED  = 3'd0,
        ST_COUNT     = 3'd1,
        ST_ALERT     = 3'd2,
        ST_RST_PULSE = 3'd3,
        ST_SPENT     = 3'd4
    } wd_state_e;

    localparam logic [3:0] OFF_CTRL  = 4'h0;
    localparam logic [3:0] OFF_TIMER = 4'h4;

endpackage

// File: rtl/wdog_load_pipe.sv
module wdog_load_pipe #(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         vld_q [LAT];
    logic [W-1:0] dat_q [LAT];

    for (genvar i = 0; i < LAT; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    dat_q[0] <= '0;
                end else begin
                    vld_q[0] <= in_valid;
                    dat_q[0] <= in_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[i] <= 1'b0;
                    dat_q[i] <= '0;
                end else begin
                    vld_q[i] <= vld_q[i-1];
                    dat_q[i] <= dat_q[i-1];
                end
            end
        end
    end

    assign out_valid = vld_q[LAT-1];
    assign out_data  = dat_q[LAT-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              por_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic [DATA_W-1:0] live_cnt,
    input  logic              rst_fire,
    output wd_act_e           action,
    output logic              flag,
    output logic              tmr_wr
);
    logic sel_ctrl, sel_tmr;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_tmr  = (bus_addr == ADDR_W'(OFF_TIMER));
    assign tmr_wr   = bus_req && bus_we && sel_tmr;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            action    <= ACT_NONE;
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_req;
            if (bus_req && bus_we && sel_ctrl)
                action <= wd_act_e'(bus_wdata[1:0]);
            if (bus_req) begin
                if (sel_ctrl)
                    bus_rdata <= {flag, {(DATA_W-3){1'b0}}, action};
                else if (sel_tmr)
                    bus_rdata <= live_cnt;
                else
                    bus_rdata <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            flag <= 1'b0;
        else if (rst_fire)
            flag <= 1'b1;
    end
endmodule

// File: rtl/wdog_fsm_core.sv
module wdog_fsm_core
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_act_e          action,
    input  logic             ld_valid,
    input  logic [CNT_W-1:0] ld_value,
    output logic [CNT_W-1:0] cnt,
    output wd_state_e        state,
    output logic             irq_gp,
    output logic             irq_nmi,
    output logic             chip_rst_req,
    output logic             rst_fire
);
    localparam int PW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    wd_state_e        st_q, st_d;
    wd_act_e          kind_q;
    logic [PW-1:0]    pls_q;
    logic [CNT_W-1:0] cnt_q;
    logic             armed, pulse_done;

    assign armed      = (action != ACT_NONE);
    assign pulse_done = (pls_q == PW'(RST_CYC - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DISARMED:  if (armed) st_d = ST_COUNT;
            ST_COUNT: begin
                if (!armed)
                    st_d = ST_DISARMED;
                else if (!ld_valid && cnt_q == '0)
                    st_d = (action == ACT_CHIP_RST) ? ST_RST_PULSE : ST_ALERT;
            end
            ST_ALERT, ST_SPENT: begin
                if (!armed)        st_d = ST_DISARMED;
                else if (ld_valid) st_d = ST_COUNT;
            end
            ST_RST_PULSE: if (pulse_done) st_d = ST_SPENT;
            default:      st_d = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_DISARMED;
            kind_q <= ACT_NONE;
            pls_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_COUNT && st_d != ST_COUNT)
                kind_q <= action;
            if (st_q != ST_RST_PULSE)
                pls_q <= '0;
            else if (!pulse_done)
                pls_q <= pls_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (ld_valid && st_q != ST_RST_PULSE)
            cnt_q <= ld_value;
        else if (st_q == ST_COUNT && armed && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    always_comb begin
        irq_gp       = (st_q == ST_ALERT) && (kind_q == ACT_IRQ);
        irq_nmi      = (st_q == ST_ALERT) && (kind_q == ACT_NMI);
        chip_rst_req = (st_q == ST_RST_PULSE);
        rst_fire     = (st_q == ST_COUNT) && (st_d == ST_RST_PULSE);
    end

    assign cnt   = cnt_q;
    assign state = st_q;
endmodule

// File: rtl/wdog_action_timer.sv
module wdog_action_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int LOAD_LAT = 3,
    parameter int RST_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              irq_gp,
    output logic              irq_nmi,
    output logic              chip_rst_req
);
    localparam int DATA_W = 32;

    logic              sys_rst_n;
    wd_act_e           action;
    logic              flag, tmr_wr, rst_fire, ld_valid;
    logic [DATA_W-1:0] ld_value, live_cnt;
    wd_state_e         state;

    assign sys_rst_n = rst_n & por_n;

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .sys_rst_n(sys_rst_n), .por_n(por_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .live_cnt(live_cnt), .rst_fire(rst_fire),
        .action(action), .flag(flag), .tmr_wr(tmr_wr)
    );

    wdog_load_pipe #(.W(DATA_W), .LAT(LOAD_LAT)) u_pipe (
        .clk(clk), .rst_n(sys_rst_n),
        .in_valid(tmr_wr), .in_data(bus_wdata),
        .out_valid(ld_valid), .out_data(ld_value)
    );

    wdog_fsm_core #(.CNT_W(DATA_W), .RST_CYC(RST_CYC)) u_core (
        .clk(clk), .rst_n(sys_rst_n), .action(action),
        .ld_valid(ld_valid), .ld_value(ld_value),
        .cnt(live_cnt), .state(state),
        .irq_gp(irq_gp), .irq_nmi(irq_nmi), .chip_rst_req(chip_rst_req),
        .rst_fire(rst_fire)
    );
endmodule

// File: rtl/wdog_action_timer_chk.sv
module wdog_action_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             sys_rst_n,
    input logic             por_n,
    input logic             bus_req,
    input logic             bus_ready,
    input logic             irq_gp,
    input logic             irq_nmi,
    input logic             chip_rst_req,
    input logic             flag,
    input logic [2:0]       st,
    input logic [1:0]       act,
    input logic             ld_valid,
    input logic [CNT_W-1:0] cnt
);
    // R3: a request is answered on the next cycle
    a_r3_ready_follows: assert property (@(posedge clk) disable iff (!sys_rst_n)
        bus_req |=> bus_ready);
    // R3: no completion without a request
    a_r3_no_spurious_ready: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !bus_req |=> !bus_ready);
    // R5: one step down per clock while counting
    a_r5_count_down: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (st == 3'd1 && act != 2'd0 && !ld_valid && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
    // R9: a disarmed counter holds its value
    a_r9_hold_disarmed: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (st == 3'd0 && !ld_valid) |=> $stable(cnt));
    // R7: the counter is frozen during the reset pulse
    a_r7_frozen_in_pulse: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (st == 3'd3) |=> $stable(cnt));
    // R8: the flag is visible while the request is high
    a_r8_flag_with_req: assert property (@(posedge clk) disable iff (!sys_rst_n)
        chip_rst_req |-> flag);
    // R8: only power-on clears the flag
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        flag |=> flag);
    // R10: action outputs are mutually exclusive
    a_r10_one_action: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $onehot0({irq_gp, irq_nmi, chip_rst_req}));
endmodule

bind wdog_action_timer wdog_action_timer_chk #(.CNT_W(32)) u_chk (
    .clk(clk), .sys_rst_n(sys_rst_n), .por_n(por_n),
    .bus_req(bus_req), .bus_ready(bus_ready),
    .irq_gp(irq_gp), .irq_nmi(irq_nmi), .chip_rst_req(chip_rst_req),
    .flag(flag), .st(state), .act(action), .ld_valid(ld_valid), .cnt(live_cnt)
);

// File: tb/wdog_action_timer_tb.sv
module wdog_action_timer_tb;
    localparam int LAT  = 3;
    localparam int RCYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, irq_gp, irq_nmi, chip_rst_req;

    always #2 clk = ~clk;

    wdog_action_timer #(.ADDR_W(4), .LOAD_LAT(LAT), .RST_CYC(RCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .irq_gp(irq_gp), .irq_nmi(irq_nmi), .chip_rst_req(chip_rst_req)
    );

    int checks = 0, errors = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_st = 0, m_pls = 0;
    logic [1:0]  m_act = 0, m_kind = 0;
    logic [31:0] m_cnt = '1, m_rdata = '0;
    bit          m_flag = 0, m_ready = 0;
    logic [32:0] m_q[$];

    always @(posedge clk) begin
        logic [32:0] head;
        int nst;
        if (!por_n) m_flag = 0;
        if (!por_n || !rst_n) begin
            m_st = 0; m_pls = 0; m_act = 0; m_kind = 0; m_cnt = '1; m_ready = 0;
            m_q = {};
            repeat (LAT) m_q.push_back('0);
        end else begin
            head = m_q.pop_front();
            m_q.push_back({bus_req && bus_we && bus_addr == 4'h4, bus_wdata});
            m_ready = bus_req;
            if (bus_req)
                m_rdata = (bus_addr == 4'h0) ? {m_flag, 29'b0, m_act} :
                          (bus_addr == 4'h4) ? m_cnt : 32'h0;
            nst = m_st;
            case (m_st)
                0: if (m_act != 0) nst = 1;
                1: if (m_act == 0) nst = 0;
                   else if (!head[32] && m_cnt == 0) begin
                       nst = (m_act == 3) ? 3 : 2;
                       m_kind = m_act;
                       m_pls = 0;
                       if (m_act == 3) m_flag = 1;
                   end
                2, 4: if (m_act == 0) nst = 0; else if (head[32]) nst = 1;
                3: if (m_pls == RCYC - 1) nst = 4; else m_pls++;
                default: nst = 0;
            endcase
            if (head[32] && m_st != 3) m_cnt = head[31:0];
            else if (m_st == 1 && m_act != 0 && m_cnt != 0) m_cnt = m_cnt - 1;
            m_st = nst;
            if (bus_req && bus_we && bus_addr == 4'h0) m_act = bus_wdata[1:0];
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && por_n) begin
            check("R6 irq_gp vs model", 32'(irq_gp), 32'(m_st == 2 && m_kind == 1));
            check("R6 irq_nmi vs model", 32'(irq_nmi), 32'(m_st == 2 && m_kind == 2));
            check("R7 chip_rst_req vs model", 32'(chip_rst_req), 32'(m_st == 3));
            check("R3 bus_ready vs model", 32'(bus_ready), 32'(m_ready));
            if (m_ready) check("R3 bus_rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        checks++; errors++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, v1, v2;
        int n;
        idle(3);
        por_n = 1; rst_n = 1;
        idle(1);
        // R1 reset state
        check("R1 outputs idle", {29'b0, irq_gp, irq_nmi, chip_rst_req}, 32'h0);
        bus_read(4'h0, d); check("R1 ctrl after power-on", d, 32'h0);
        bus_read(4'h4, d); check("R1 counter after power-on", d, 32'hFFFF_FFFF);

        // R4 load latency
        bus_write(4'h4, 32'd20);
        bus_read(4'h4, d); check("R4 read before load lands", d, 32'hFFFF_FFFF);
        idle(LAT);
        bus_read(4'h4, d); check("R4 loaded value, R9 held while disarmed", d, 32'd20);

        // R6 general interrupt
        bus_write(4'h0, 32'd1);
        idle(30);
        check("R6 irq_gp on expiry", 32'(irq_gp), 32'd1);
        bus_read(4'h4, d); check("R5 counter held at zero", d, 32'h0);
        bus_read(4'h0, d); check("R2 ctrl action readback", d, 32'h1);

        // reload clears, re-expires
        bus_write(4'h4, 32'd5);
        idle(LAT);
        check("R6 irq_gp cleared by reload", 32'(irq_gp), 32'd0);
        idle(20);
        check("R6 irq_gp after second expiry", 32'(irq_gp), 32'd1);
        bus_write(4'h0, 32'd0);
        idle(2);
        check("R9 action 0 drops irq_gp", 32'(irq_gp), 32'd0);

        // R5 decrement rate
        bus_write(4'h4, 32'd60);
        idle(LAT + 1);
        bus_write(4'h0, 32'd1);
        idle(3);
        bus_read(4'h4, v1);
        idle(4);
        bus_read(4'h4, v2);
        check("R5 five ticks between reads", v1 - v2, 32'd5);
        bus_write(4'h0, 32'd0);
        idle(2);

        // R6 non-maskable interrupt, R10
        bus_write(4'h4, 32'd6);
        idle(5);
        bus_write(4'h0, 32'd2);
        idle(20);
        check("R6 irq_nmi on expiry", 32'(irq_nmi), 32'd1);
        check("R10 irq_gp stays low", 32'(irq_gp), 32'd0);
        bus_write(4'h0, 32'd0);
        idle(2);
        check("R9 action 0 drops irq_nmi", 32'(irq_nmi), 32'd0);

        // R7 chip reset pulse, load ignored during pulse
        bus_write(4'h4, 32'd4);
        idle(5);
        bus_write(4'h0, 32'd3);
        n = 0;
        while (!chip_rst_req && n < 50) begin idle(1); n++; end
        n = 1;
        bus_write(4'h4, 32'd100);
        while (chip_rst_req && n < 50) begin n++; idle(1); end
        check("R7 pulse length", 32'(n), 32'(RCYC));
        idle(LAT);
        bus_read(4'h4, d); check("R7 load during pulse dropped", d, 32'h0);
        bus_read(4'h0, d); check("R8 flag set with action 3", d, 32'h8000_0003);

        // R8 flag survives system reset
        rst_n = 0; idle(3); rst_n = 1; idle(1);
        bus_read(4'h0, d); check("R8 flag survives rst_n", d, 32'h8000_0000);
        bus_read(4'h4, d); check("R1 counter after rst_n", d, 32'hFFFF_FFFF);
        por_n = 0; idle(3); por_n = 1; idle(1);
        bus_read(4'h0, d); check("R8 por_n clears flag", d, 32'h0);

        // R2 unmapped offset and reserved bits
        bus_write(4'h8, 32'h3);
        bus_read(4'h8, d); check("R2 unmapped reads zero", d, 32'h0);
        bus_read(4'h0, d); check("R2 unmapped write ignored", d, 32'h0);
        bus_write(4'h0, 32'hFFFF_FFFE);
        bus_read(4'h0, d); check("R2 only action bits stored", d, 32'h2);
        bus_write(4'h0, 32'h0);
        idle(4);
        finish_run();
    end
endmodule